// File: doc/BRIEF.md
# Bidirectional 8-bit Timer with Dual Compare

An 8-bit counter that advances only on a selected timer tick while everything stays synchronous to one system clock. A 3-bit select picks the tick source. Code 0 means no source and the counter halts. Codes 1 to 5 take one of five prescaled ticks that an outside divider supplies. Codes 6 and 7 take an external pin, passed through a two-flop synchronizer and edge-detected on the falling or the rising edge. On each tick the counter is cleared, incremented or decremented, according to a clear input and a direction input.

A host port loads the count directly, and that load wins over any tick action in the same cycle. Two compare channels each hold a buffered value that the host writes. A buffered value moves to its active register whenever the count sits at zero. A tick on which the count equals an active value raises that channel's match flag. An increment that wraps 255 to 0 raises an overflow flag. The flags stay set until the host clears them by writing a one, and a single interrupt request combines the enabled flags.

Top module: `tmr8_core`

## Requirements
- R1: With `clk_sel` = 0 no tick occurs, and the count changes only through a host load.
- R2: With `clk_sel` = k for k in 1..5, a tick occurs in a cycle exactly when `presc_tick[k-1]` is high; the other prescaled inputs and `ext_pin` have no effect.
- R3: With `clk_sel` = 6 a tick follows each falling edge of `ext_pin`, and with 7 each rising edge; the count changes at the third rising clock edge after the pin change is first sampled.
- R4: On a tick with no host load, `count` becomes 0 if `count_clear` = 1, else `count`-1 (mod 256) if `count_down` = 1, else `count`+1 (mod 256).
- R5: When `host_cnt_wr` = 1, `count` takes `host_wdata` at the next edge, whatever the tick, clear and direction inputs are.
- R6: `at_top` is 1 exactly when `count` = 255, and `at_bottom` is 1 exactly when `count` = 0.
- R7: `flags[0]` (overflow) sets on a tick with no host load, no clear and direction up, while `count` = 255.
- R8: `host_cmp_wr[0]`/`[1]` write `host_wdata` only into the buffer of channel A/B; in every cycle where `count` = 0 each active compare value takes its buffer at the next edge.
- R9: `flags[1]` (channel A) and `flags[2]` (channel B) set on a tick in a cycle with no host load while `count` equals that channel's active value.
- R10: A flag stays set until a cycle with the matching `host_flag_clr` bit at 1 and no set event; a set event in the same cycle wins.
- R11: `irq` is 1 exactly when some bit is set in both `flags` and `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_sel | input | 3 | Tick source: 0 off, 1..5 prescaled, 6 pin falling, 7 pin rising |
| presc_tick | input | 5 | One-cycle ticks from the outside prescaler |
| ext_pin | input | 1 | Asynchronous external count pin |
| count_down | input | 1 | 1 decrements, 0 increments |
| count_clear | input | 1 | Clear the count on a tick |
| host_cnt_wr | input | 1 | Host load of the count |
| host_wdata | input | 8 | Host write data for count and compare buffers |
| host_cmp_wr | input | 2 | Host write to compare buffer A (bit 0) or B (bit 1) |
| host_flag_clr | input | 3 | Write-one-to-clear for flags |
| irq_en | input | 3 | Per-flag interrupt enable |
| count | output | 8 | Current count |
| at_top | output | 1 | Count equals 255 |
| at_bottom | output | 1 | Count equals 0 |
| flags | output | 3 | Overflow (0), match A (1), match B (2) |
| irq | output | 1 | Combined enabled interrupt request |

## Verification
The bench goes after the priority of a host load over a tick. If the priority were wrong, the count would step or clear instead of taking the written value, and a match could be flagged on the load cycle. It drives both pin edges through the synchronizer: a design with a missing or extra stage would move the count a cycle early or late, and one with the edge inverted would count the wrong transition. It crosses 255 to 0 and 0 to 255 in both directions, so an overflow raised on down-wraps or on clears is caught. Compare writes made away from zero show whether the active values update too early, and clears issued together with set events show whether a set is lost.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int CNT_W    = 8;
  localparam int SEL_W    = 3;
  localparam int N_PRE    = 5;
  localparam int N_CMP    = 2;
  localparam int N_FLAGS  = N_CMP + 1;
  localparam int FLAG_OVF = 0;
  localparam logic [SEL_W-1:0] SEL_OFF      = 3'd0;
  localparam logic [SEL_W-1:0] SEL_EXT_FALL = 3'd6;
  localparam logic [SEL_W-1:0] SEL_EXT_RISE = 3'd7;
endpackage

// File: rtl/tmr_tick_sel.sv
`timescale 1ns/1ps
module tmr_tick_sel
  import tmr_pkg::*;
#(
  parameter int NP = N_PRE
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [NP-1:0]    presc_i,
  input  logic             pin_i,
  output logic             tick_o
);
  logic s1_q, s2_q, prev_q;
  logic s1_d, s2_d, prev_d;
  logic rise, fall;

  always_comb begin
    s1_d   = pin_i;
    s2_d   = s1_q;
    prev_d = s2_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= s1_d;
      s2_q   <= s2_d;
      prev_q <= prev_d;
    end
  end

  assign rise = s2_q & ~prev_q;
  assign fall = ~s2_q & prev_q;

  always_comb begin
    tick_o = 1'b0;
    if (sel_i == SEL_EXT_FALL)      tick_o = fall;
    else if (sel_i == SEL_EXT_RISE) tick_o = rise;
    else begin
      for (int i = 0; i < NP; i++)
        if (int'(sel_i) == i + 1) tick_o = presc_i[i];
    end
  end
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clr_i,
  input  logic         dn_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_evt_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = wr_i | tick_i;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_i)        cnt_d = wdata_i;
    else if (clr_i)  cnt_d = '0;
    else if (dn_i)   cnt_d = cnt_q - 1'b1;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o     = cnt_q;
  assign ovf_evt_o = tick_i & ~wr_i & ~clr_i & ~dn_i & (cnt_q == '1);

  // R1: without tick or load the count holds
  p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    (!tick_i && !wr_i) |=> $stable(cnt_q));
  // R5: host load wins
  p_host_load_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_i |=> (cnt_q == $past(wdata_i)));
  // R7: overflow event lands on zero
  p_ovf_wrap_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    ovf_evt_o |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_cmp_chan.sv
`timescale 1ns/1ps
module tmr_cmp_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         buf_wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] cnt_i,
  input  logic         at_bottom_i,
  input  logic         tick_ok_i,
  output logic         match_o
);
  logic [W-1:0] buf_q, buf_d, act_q, act_d;

  always_comb begin
    buf_d = buf_wr_i ? wdata_i : buf_q;
    act_d = at_bottom_i ? buf_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      buf_q <= buf_d;
      act_q <= act_d;
    end
  end

  assign match_o = tick_ok_i & (cnt_i == act_q);

  // R8: active value reloads from buffer at bottom
  p_act_load_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(at_bottom_i) |-> (act_q == $past(buf_q)));
endmodule

// File: rtl/tmr_flags.sv
`timescale 1ns/1ps
module tmr_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  logic [N-1:0] flg_q, flg_d;

  always_comb flg_d = (flg_q & ~clr_i) | set_i;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) flg_q <= '0;
    else         flg_q <= flg_d;
  end

  assign flags_o = flg_q;
  assign irq_o   = |(flg_q & en_i);

  // R10: a flag only rises from a set event
  p_flag_cause_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    ((flg_q & ~$past(flg_q) & ~$past(set_i)) == '0));
  // R10: a clear without set empties the flag
  p_flag_clr_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (($past(clr_i & ~set_i) & flg_q) == '0));
endmodule

// File: rtl/tmr8_core.sv
`timescale 1ns/1ps
module tmr8_core
  import tmr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEL_W-1:0]   clk_sel,
  input  logic [N_PRE-1:0]   presc_tick,
  input  logic               ext_pin,
  input  logic               count_down,
  input  logic               count_clear,
  input  logic               host_cnt_wr,
  input  logic [CNT_W-1:0]   host_wdata,
  input  logic [N_CMP-1:0]   host_cmp_wr,
  input  logic [N_FLAGS-1:0] host_flag_clr,
  input  logic [N_FLAGS-1:0] irq_en,
  output logic [CNT_W-1:0]   count,
  output logic               at_top,
  output logic               at_bottom,
  output logic [N_FLAGS-1:0] flags,
  output logic               irq
);
  logic rst_s1_q, rst_s2_q, rst_int;
  logic tick, ovf_evt, tick_ok;
  logic [CNT_W-1:0]   cnt;
  logic [N_CMP-1:0]   match;
  logic [N_FLAGS-1:0] set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int = rst_s2_q;

  tmr_tick_sel #(.NP(N_PRE)) u_tick (
    .clk(clk), .rst_ni(rst_int), .sel_i(clk_sel), .presc_i(presc_tick),
    .pin_i(ext_pin), .tick_o(tick));

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_ni(rst_int), .tick_i(tick), .clr_i(count_clear),
    .dn_i(count_down), .wr_i(host_cnt_wr), .wdata_i(host_wdata),
    .cnt_o(cnt), .ovf_evt_o(ovf_evt));

  assign tick_ok   = tick & ~host_cnt_wr;
  assign at_top    = (cnt == '1);
  assign at_bottom = (cnt == '0);

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    tmr_cmp_chan #(.W(CNT_W)) u_chan (
      .clk(clk), .rst_ni(rst_int), .buf_wr_i(host_cmp_wr[g]),
      .wdata_i(host_wdata), .cnt_i(cnt), .at_bottom_i(at_bottom),
      .tick_ok_i(tick_ok), .match_o(match[g]));
  end

  assign set_vec = {match, ovf_evt};

  tmr_flags #(.N(N_FLAGS)) u_flags (
    .clk(clk), .rst_ni(rst_int), .set_i(set_vec), .clr_i(host_flag_clr),
    .en_i(irq_en), .flags_o(flags), .irq_o(irq));

  assign count = cnt;

  // R6: top and bottom never together
  p_top_bottom_r6: assert property (@(posedge clk) disable iff (!rst_int)
    !(at_top && at_bottom));
endmodule

// File: tb/tmr8_core_tb.sv
`timescale 1ns/1ps
module tmr8_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] clk_sel = '0;
  logic [4:0] presc_tick = '0;
  logic       ext_pin = 1'b0;
  logic       count_down = 1'b0, count_clear = 1'b0, host_cnt_wr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [1:0] host_cmp_wr = '0;
  logic [2:0] host_flag_clr = '0, irq_en = '0;
  logic [7:0] count;
  logic       at_top, at_bottom, irq;
  logic [2:0] flags;

  int total = 0, bad = 0;
  bit hold = 1'b1, done = 1'b0;
  string req = "R6";

  int m_cnt, m_bufa, m_bufb, m_acta, m_actb, m_flags, m_s1, m_s2, m_prev;

  always #2.5 clk = ~clk;

  tmr8_core u_dut (.*);

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    int tk, nc, ev;
    if (hold) begin
      m_cnt = 0; m_bufa = 0; m_bufb = 0; m_acta = 0; m_actb = 0;
      m_flags = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
    end else begin
      tk = 0;
      if (clk_sel == 6) tk = (m_s2 == 0 && m_prev == 1) ? 1 : 0;
      else if (clk_sel == 7) tk = (m_s2 == 1 && m_prev == 0) ? 1 : 0;
      else if (clk_sel != 0) tk = int'(presc_tick[int'(clk_sel) - 1]);
      nc = m_cnt;
      if (host_cnt_wr) nc = int'(host_wdata);
      else if (tk == 1) begin
        if (count_clear) nc = 0;
        else if (count_down) nc = (m_cnt + 255) % 256;
        else nc = (m_cnt + 1) % 256;
      end
      ev = 0;
      if (!host_cnt_wr && tk == 1) begin
        if (!count_clear && !count_down && m_cnt == 255) ev |= 1;
        if (m_cnt == m_acta) ev |= 2;
        if (m_cnt == m_actb) ev |= 4;
      end
      m_flags = (m_flags & ~int'(host_flag_clr)) | ev;
      if (m_cnt == 0) begin m_acta = m_bufa; m_actb = m_bufb; end
      if (host_cmp_wr[0]) m_bufa = int'(host_wdata);
      if (host_cmp_wr[1]) m_bufb = int'(host_wdata);
      m_prev = m_s2; m_s2 = m_s1; m_s1 = int'(ext_pin);
      m_cnt = nc;
    end
  end

  task automatic chk(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!hold && !done) begin
      chk("count", int'(count), m_cnt);
      chk("at_top R6", int'(at_top), (m_cnt == 255) ? 1 : 0);
      chk("at_bottom R6", int'(at_bottom), (m_cnt == 0) ? 1 : 0);
      chk("flags", int'(flags), m_flags);
      chk("irq R11", int'(irq), ((m_flags & int'(irq_en)) != 0) ? 1 : 0);
    end
  end

  task automatic nxt();
    @(negedge clk); #1;
  endtask

  task automatic quiet();
    presc_tick = '0; host_cnt_wr = 0; host_cmp_wr = '0; host_flag_clr = '0;
    count_clear = 0;
  endtask

  task automatic load(int v);
    host_cnt_wr = 1; host_wdata = 8'(v); nxt(); host_cnt_wr = 0;
  endtask

  initial begin
    repeat (3) nxt();
    rst_n = 1'b1;
    repeat (5) nxt();
    hold = 1'b0;
    req = "R6"; nxt();
    chk("reset count R6", int'(count), 0);
    chk("reset bottom R6", int'(at_bottom), 1);

    // R1: stopped, noise on every tick input
    req = "R1"; clk_sel = 0;
    for (int i = 0; i < 30; i++) begin
      presc_tick = 5'($urandom); ext_pin = 1'($urandom); nxt();
    end
    chk("stopped count R1", int'(count), 0);

    // R2: each prescaled input selected in turn
    req = "R2";
    for (int s = 1; s <= 5; s++) begin
      clk_sel = 3'(s);
      for (int i = 0; i < 40; i++) begin
        presc_tick = 5'($urandom); ext_pin = 1'($urandom); nxt();
      end
    end
    quiet();

    // R3: pin edges, both polarities, with latency probe
    req = "R3";
    for (int s = 6; s <= 7; s++) begin
      clk_sel = 3'(s);
      for (int i = 0; i < 60; i++) begin
        if ($urandom_range(0, 2) == 0) ext_pin = ~ext_pin;
        nxt();
      end
    end
    clk_sel = 7; ext_pin = 0; repeat (4) nxt();
    load(10); ext_pin = 1;
    nxt(); chk("pin +1 R3", int'(count), 10);
    nxt(); chk("pin +2 R3", int'(count), 10);
    nxt(); chk("pin +3 R3", int'(count), 11);

    // R4: direction and clear across both wraps
    req = "R4"; clk_sel = 1; presc_tick = 5'b00001;
    load(254); count_down = 0; repeat (4) nxt();
    load(1); count_down = 1; repeat (4) nxt();
    count_clear = 1; nxt(); count_clear = 0; count_down = 0;
    chk("clear R4", int'(count), 0);

    // R5: load together with tick and clear
    req = "R5";
    for (int i = 0; i < 40; i++) begin
      host_cnt_wr = 1'($urandom); host_wdata = 8'($urandom);
      count_clear = 1'($urandom); count_down = 1'($urandom); nxt();
    end
    quiet(); presc_tick = 5'b00001;

    // R7: overflow only on up-wrap
    req = "R7"; irq_en = 3'b001;
    load(253); count_down = 0; repeat (4) nxt();
    host_flag_clr = 3'b001; nxt(); host_flag_clr = 0;
    load(0); count_down = 1; repeat (3) nxt();
    count_down = 0;

    // R8/R9: buffers load only at bottom
    req = "R8"; load(5);
    host_wdata = 8'd9; host_cmp_wr = 2'b01; nxt();
    host_wdata = 8'd12; host_cmp_wr = 2'b10; nxt(); host_cmp_wr = 0;
    repeat (10) nxt();
    req = "R9"; load(0); repeat (20) nxt();

    // R10/R11: clear with and without simultaneous set
    req = "R10";
    for (int i = 0; i < 200; i++) begin
      presc_tick = 5'($urandom); host_flag_clr = 3'($urandom);
      irq_en = 3'($urandom); nxt();
    end
    req = "R11";
    for (int e = 0; e < 8; e++) begin irq_en = 3'(e); nxt(); end

    // mixed traffic over every input
    req = "R4";
    for (int i = 0; i < 3000; i++) begin
      clk_sel = 3'($urandom); presc_tick = 5'($urandom);
      if ($urandom_range(0, 3) == 0) ext_pin = ~ext_pin;
      count_down = 1'($urandom); count_clear = ($urandom_range(0, 15) == 0);
      host_cnt_wr = ($urandom_range(0, 15) == 0); host_wdata = 8'($urandom);
      host_cmp_wr = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00;
      host_flag_clr = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000;
      irq_en = 3'($urandom); nxt();
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1; total++; bad++;
      $display("FAIL watchdog all requirements act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule